// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point words and returns their product in the same format. Each word holds a sign in bit 31, a biased exponent in bits 30..23 (bias 127) and a 23-bit fraction in bits 22..0, with a hidden leading 1. An operand whose exponent field is zero counts as zero, so denormals are flushed. An all-ones exponent field gets no special meaning and is read as an ordinary exponent of 255. The product is rounded to nearest, with ties going to even. Exponent overflow and underflow are reported on two flag pins.

Operand pairs enter on a valid/ready stream, and results leave on a second valid/ready stream. A pair is taken on any clock edge where `in_valid` and `in_ready` are both high. Its result is registered and shown one cycle later. The result register is the only storage, and `in_ready` is high whenever that register is empty or is being drained in the same cycle. A consumer that holds `out_ready` low therefore stalls the producer at once, and the held result does not change until it is taken.

Top module: `fp32_mul_stream`

## Requirements
- R1: The result sign (bit 31) is the XOR of the two input signs, for zero, overflow and underflow results as well.
- R2: For normal operands, the result exponent field equals the sum of the two exponent fields minus 127, plus any normalization increments. For example, 0x3F000000 × 0xBEE00000 gives 0xBE600000.
- R3: When the product of the two 24-bit significands is 2.0 or more, it is shifted right by one place and the exponent goes up by one. For example, 1.5 × 1.5 gives 0x40100000.
- R4: Rounding looks at a guard bit, a round bit and a sticky bit. The product rounds down when below half an ULP and up when above half. An exact half rounds to the even fraction: 0x3F800001 × 0x3FC00000 gives 0x3FC00002, and 0x3F800003 × 0x3FC00000 gives 0x3FC00004.
- R5: If rounding carries out of the significand, the result is shifted right once more and the exponent goes up by one. For example, 0x3FFFF800 × 0x3F800400 gives 0x40000000.
- R6: A final exponent of 255 or more gives a signed infinity (exponent field all ones, fraction 0) with `out_ovf` = 1, including overflow caused by the rounding carry of R5. A final exponent of 254 is still a finite result.
- R7: A final exponent of 0 or less gives a signed zero with `out_unf` = 1.
- R8: An operand with a zero exponent field makes the result a signed zero with both flags at 0, whatever the other operand is.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data`, `out_ovf` and `out_unf` hold their values. Input presented during that time is not taken.
- R10: A pair accepted on one edge sets `out_valid` after that same edge. After reset `out_valid` is 0 and `in_ready` is 1. `out_valid` falls once the result is taken and no new pair arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Rounded product |
| out_ovf | output | 1 | Result overflowed to infinity |
| out_unf | output | 1 | Result underflowed to zero |

## Verification
The bench uses exact-half products on both an odd and an even significand. A design that truncates, or rounds half away from zero, then gives a value one ULP off. It also builds a product whose 24 kept bits and guard bit are all ones. If the second normalization after rounding is missing, this case yields 1.0 instead of 2.0; the same case one octave below the top exponent must overflow, not show a large finite value. It probes both sides of the exponent range and a denormal operand, which a design without flushing would treat as a tiny normal number. Last, it stalls the output with a different pair waiting at the input, which catches a design that overwrites or drops the held result.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // Bits below the kept significand that drive the rounding decision.
  typedef struct packed {
    logic guard;
    logic rnd;
    logic sticky;
  } grs_t;

  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  expo,
  output logic [SIG_W-1:0]  sig,
  output logic              is_zero
);
  assign sign    = word[WORD_W-1];
  assign expo    = word[WORD_W-2 -: EXP_W];
  // A zero exponent field flushes the operand to zero (no denormals).
  assign is_zero = (expo == '0);
  assign sig     = {1'b1, word[FRAC_W-1:0]};
endmodule

// File: rtl/fpm_sig_mult.sv
module fpm_sig_mult
  import fpm_pkg::*;
#(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int SEXP_W = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input  logic [SIG_W-1:0]         sig_a,
  input  logic [SIG_W-1:0]         sig_b,
  input  logic [EXP_W-1:0]         exp_a,
  input  logic [EXP_W-1:0]         exp_b,
  output logic [SIG_W-1:0]         kept,
  output grs_t                     grs,
  output logic signed [SEXP_W-1:0] expo
);
  logic [PROD_W-1:0] prod;
  logic              hi;

  assign prod = sig_a * sig_b;
  // The product of two values in [1,2) lies in [1,4); the top bit marks >= 2.
  assign hi   = prod[PROD_W-1];

  always_comb begin
    if (hi) begin
      kept       = prod[PROD_W-1 -: SIG_W];
      grs.guard  = prod[SIG_W-1];
      grs.rnd    = prod[SIG_W-2];
      grs.sticky = |prod[SIG_W-3:0];
    end else begin
      kept       = prod[PROD_W-2 -: SIG_W];
      grs.guard  = prod[SIG_W-2];
      grs.rnd    = prod[SIG_W-3];
      grs.sticky = |prod[SIG_W-4:0];
    end
  end

  // Biased exponents add, bias removed once, normalization shift folded in.
  assign expo = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b})
              - $signed(SEXP_W'(BIAS)) + $signed({{(SEXP_W-1){1'b0}}, hi});
endmodule

// File: rtl/fpm_round_pack.sv
module fpm_round_pack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W,
  localparam int SIG_W   = FRAC_W + 1,
  localparam int SEXP_W  = EXP_W + 2,
  localparam int EXP_TOP = (1 << EXP_W) - 1
) (
  input  logic                     sign,
  input  logic                     zero_in,
  input  logic [SIG_W-1:0]         kept,
  input  grs_t                     grs,
  input  logic signed [SEXP_W-1:0] expo,
  output logic [WORD_W-1:0]        word,
  output logic                     ovf,
  output logic                     unf
);
  logic                     bump;
  logic [SIG_W:0]           rsum;
  logic [FRAC_W-1:0]        frac;
  logic signed [SEXP_W-1:0] fexp;

  // Nearest-even: up above half, and on exact half only when the LSB is odd.
  assign bump = grs.guard & (grs.rnd | grs.sticky | kept[0]);
  assign rsum = {1'b0, kept} + {{SIG_W{1'b0}}, bump};

  // Second normalization: a carry out of the significand means 10.0.
  always_comb begin
    if (rsum[SIG_W]) begin
      frac = rsum[FRAC_W:1];
      fexp = expo + SEXP_W'(1);
    end else begin
      frac = rsum[FRAC_W-1:0];
      fexp = expo;
    end
  end

  always_comb begin
    ovf  = 1'b0;
    unf  = 1'b0;
    word = {sign, {(WORD_W-1){1'b0}}};
    if (zero_in) begin
      word = {sign, {(WORD_W-1){1'b0}}};
    end else if (fexp >= $signed(SEXP_W'(EXP_TOP))) begin
      ovf  = 1'b1;
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (fexp <= $signed(SEXP_W'(0))) begin
      unf  = 1'b1;
    end else begin
      word = {sign, fexp[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp32_mul_stream.sv
module fp32_mul_stream
  import fpm_pkg::*;
#(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W,
  localparam int SIG_W   = FRAC_W + 1,
  localparam int SEXP_W  = EXP_W + 2,
  localparam int N_OPND  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_ovf,
  output logic              out_unf
);
  logic [WORD_W-1:0] opnd   [N_OPND];
  logic              op_sgn [N_OPND];
  logic [EXP_W-1:0]  op_exp [N_OPND];
  logic [SIG_W-1:0]  op_sig [N_OPND];
  logic              op_zero[N_OPND];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word   (opnd[gi]),
      .sign   (op_sgn[gi]),
      .expo   (op_exp[gi]),
      .sig    (op_sig[gi]),
      .is_zero(op_zero[gi])
    );
  end

  logic [SIG_W-1:0]         kept;
  grs_t                     grs;
  logic signed [SEXP_W-1:0] pexp;

  fpm_sig_mult #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mult (
    .sig_a(op_sig[0]),
    .sig_b(op_sig[1]),
    .exp_a(op_exp[0]),
    .exp_b(op_exp[1]),
    .kept (kept),
    .grs  (grs),
    .expo (pexp)
  );

  logic [WORD_W-1:0] res_word;
  logic              res_ovf;
  logic              res_unf;

  fpm_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sign   (op_sgn[0] ^ op_sgn[1]),
    .zero_in(op_zero[0] | op_zero[1]),
    .kept   (kept),
    .grs    (grs),
    .expo   (pexp),
    .word   (res_word),
    .ovf    (res_ovf),
    .unf    (res_unf)
  );

  logic accept;
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= res_word;
        out_ovf   <= res_ovf;
        out_unf   <= res_unf;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: a stalled result neither moves nor lets new input in.
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_ovf) && $stable(out_unf)));

  // R10: an accepted pair is presented after the same edge.
  a_r10_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R1: result sign follows the XOR of the accepted signs.
  a_r1_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (out_data[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1])));

  // R6: overflow always shows an infinity pattern.
  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |->
      (out_data[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && !out_unf));

  // R7: underflow always shows a zero magnitude.
  a_r7_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_data[WORD_W-2:0] == '0));

  // R8: a flushed operand never raises a flag.
  a_r8_zero_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_a[WORD_W-2 -: EXP_W] == '0 || in_b[WORD_W-2 -: EXP_W] == '0))
      |=> (!out_ovf && !out_unf && out_data[WORD_W-2:0] == '0));
endmodule

// File: tb/sim_fp32_mul_stream.sv
module sim_fp32_mul_stream;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_ovf;
  logic        out_unf;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_mul_stream u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Send one pair with the output free, then check word and flags.
  task automatic mul_chk(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp_w, input bit e_ovf,
                         input bit e_unf, input string req);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk(out_data == exp_w, {req, " data"}, out_data, exp_w);
    chk({out_ovf, out_unf} == {e_ovf, e_unf}, {req, " flags"},
        {30'd0, out_ovf, out_unf}, {30'd0, e_ovf, e_unf});
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R10 reset in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_basic;
    mul_chk(32'h3F000000, 32'hBEE00000, 32'hBE600000, 0, 0, "R2 0.5*-0.4375");
    mul_chk(32'h40000000, 32'h40400000, 32'h40C00000, 0, 0, "R2 2*3");
    mul_chk(32'hC0400000, 32'hC0000000, 32'h40C00000, 0, 0, "R1 neg*neg");
    mul_chk(32'hC0400000, 32'h40000000, 32'hC0C00000, 0, 0, "R1 neg*pos");
  endtask

  task automatic t_norm;
    mul_chk(32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0, "R3 1.5*1.5");
  endtask

  task automatic t_round;
    mul_chk(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0, "R4 tie odd up");
    mul_chk(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, 0, "R4 tie even kept");
    mul_chk(32'h3F800001, 32'h3F800001, 32'h3F800002, 0, 0, "R4 below half");
  endtask

  task automatic t_carry;
    mul_chk(32'h3FFFF800, 32'h3F800400, 32'h40000000, 0, 0, "R5 round carry");
  endtask

  task automatic t_overflow;
    mul_chk(32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0, "R6 overflow pos");
    mul_chk(32'h7F000000, 32'hC0000000, 32'hFF800000, 1, 0, "R6 overflow neg");
    mul_chk(32'h7F7FF800, 32'h3F800400, 32'h7F800000, 1, 0, "R6 overflow by rounding");
    mul_chk(32'h7F000000, 32'h3F800000, 32'h7F000000, 0, 0, "R6 top finite");
  endtask

  task automatic t_underflow;
    mul_chk(32'h00800000, 32'h3F000000, 32'h00000000, 0, 1, "R7 underflow pos");
    mul_chk(32'h80800000, 32'h3F000000, 32'h80000000, 0, 1, "R7 underflow neg");
  endtask

  task automatic t_zero;
    mul_chk(32'h00000001, 32'h40000000, 32'h00000000, 0, 0, "R8 denormal flush");
    mul_chk(32'h80000000, 32'h3F800000, 32'h80000000, 0, 0, "R8 negative zero");
    mul_chk(32'h7F000000, 32'h00000000, 32'h00000000, 0, 0, "R8 huge*zero");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    in_a = 32'h40000000; in_b = 32'h40400000; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    #1;
    in_a = 32'h3FC00000; in_b = 32'h3FC00000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      chk(in_ready == 1'b0, "R9 stalled in_ready", {31'd0, in_ready}, 32'd0);
      chk(out_valid && out_data == 32'h40C00000, "R9 held data", out_data, 32'h40C00000);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(out_valid && out_data == 32'h40100000, "R9 next after release", out_data, 32'h40100000);
  endtask

  task automatic t_drain;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 drained", {31'd0, out_valid}, 32'd0);
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 idle stays empty", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_norm();
    t_round();
    t_carry();
    t_overflow();
    t_underflow();
    t_zero();
    t_drain();
    t_backpressure();
    t_drain();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule